// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when a microcontroller's core is held in reset, for how long, and which startup configuration it sees afterwards. Four sources can request a reset. They are an external reset line, a software request, a watchdog overflow, and a low-supply condition. The low-supply condition counts only while the external line is held low, and it forces reset at once. A granted request starts a fixed-length sequence. The length is given in clock-phase units and converted to clocks by a parameter. When the sequence ends, configuration bits are captured from a parallel port. The capture rule depends on which source started the sequence.

A watchdog overflow that arrives during an external bus cycle does not reset the core straight away. The block first lets the bus cycle finish, or aborts it, based on the ready level sampled after the wait states. A bounded timeout ensures a stuck ready signal cannot hold reset off indefinitely. The block also drives a reset-out indication. This indication stays asserted after the sequence ends and is released only by an end-of-initialization strobe. In addition, the block can pull the reset-in pin low during internally generated resets when software has armed that feature.

Top module: `reset_sequencer`

## Requirements
- R1: The internal reset output stays high for exactly SEQ_UNITS/TCL_PER_CLK clocks after the clock edge that accepts the last reset request. It then falls, and the configuration is captured on that same edge.
- R2: A sequence started by the external line or by the low-supply condition captures every port bit into the configuration output.
- R3: A sequence started by software captures port bits 12..8 and clears configuration bits 7..2. Configuration bits 15..13 and 1..0 keep their previous value.
- R4: A sequence started by the watchdog applies the same capture rule as R3.
- R5: A watchdog overflow while the bus is active holds off internal reset until the bus cycle ends. The cycle ends when busActive drops, or when busWaitDone is seen with readyN low. If busWaitDone is seen with readyN high, busAbort is high in that cycle and the sequence starts on the next edge.
- R6: If the wait of R5 has not ended after BUS_TMO clocks, busAbort rises for one cycle and the sequence starts.
- R7: rstOutLow is high after rstN and whenever a sequence starts. It falls one edge after einit is seen outside reset. An einit pulse during reset is ignored.
- R8: While the pulldown enable bit is set (written through pdEnWr when no reset is active), rstInPullLow is high during software and watchdog sequences and low during external ones. Every sequence end clears the enable bit.
- R9: When supplyLow and rstInLow are both high, intRst goes high in the same cycle and stays high. After the condition clears, a full R1 sequence follows, and the cause reads 3.
- R10: Requests arriving in the same cycle are ranked low-supply, then external, then watchdog, then software. rstCause records the winner: software = 0, watchdog = 1, external = 2, low-supply = 3. Its value after rstN is 2.
- R11: A request that arrives during a running sequence restarts the R1 count. The capture rule of that newest source is the one applied.
- R12: External and software requests start the sequence on the next edge even while the bus is active, and they never raise busAbort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| rstInLow | input | 1 | External reset line asserted (pin low) |
| supplyLow | input | 1 | Supply monitor reports below threshold |
| swRstReq | input | 1 | Software reset request pulse |
| wdtOvf | input | 1 | Watchdog overflow pulse |
| busActive | input | 1 | An external bus cycle is running |
| busUsesReady | input | 1 | The running cycle is terminated by ready |
| busWaitDone | input | 1 | Programmed wait states have elapsed; ready is sampled this cycle |
| readyN | input | 1 | Bus ready, active low |
| einit | input | 1 | End-of-initialization strobe |
| pdEnWr | input | 1 | Write strobe for the pulldown enable bit |
| pdEnWrData | input | 1 | Value written to the pulldown enable bit |
| portIn | input | PORT_W | Parallel port sampled for startup configuration |
| intRst | output | 1 | Internal reset to the core |
| rstOutLow | output | 1 | Reset-out indication asserted |
| rstInPullLow | output | 1 | Drive the reset-in pin low |
| busAbort | output | 1 | Abort the running bus cycle |
| cfgOut | output | PORT_W | Latched startup configuration |
| rstCause | output | 2 | Source of the most recent accepted request |

## Verification
The bench builds the block with SEQ_UNITS = 16 and TCL_PER_CLK = 2, which gives an 8-clock sequence, and with BUS_TMO = 4. At these sizes the exact reset length, the restart count and the timeout edge can each be counted cycle by cycle. The port stays 16 bits wide with the standard field split. This lets the bench sweep every source across a series of computed port patterns and compare cfgOut against an arithmetic model of the full and partial capture rules. Small windows also make the bus-wait exits, same-cycle priority and pulldown cases cheap to cover one after another.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  typedef enum logic [1:0] {
    SRC_SW    = 2'd0,
    SRC_WDT   = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_ASYNC = 2'd3
  } rstSrc_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BUSWAIT,
    ST_SEQ,
    ST_ASYNC
  } seqState_e;

  typedef struct packed {
    logic    cntClr;
    logic    cntInc;
    logic    tmoClr;
    logic    tmoInc;
    logic    latchFull;
    logic    latchHi;
    logic    pdClr;
    logic    pdLd;
    logic    causeLd;
    rstSrc_e causeVal;
  } seqStrobe_t;

endpackage

// File: rtl/reset_seq_dp.sv
module reset_seq_dp
  import reset_seq_pkg::*;
#(
  parameter int PORT_W   = 16,
  parameter int SEQ_CLKS = 512,
  parameter int BUS_TMO  = 16,
  parameter int HI_MSB   = 12,
  parameter int HI_LSB   = 8,
  parameter int LO_MSB   = 7,
  parameter int LO_LSB   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [PORT_W-1:0] portIn,
  input  logic              pdEnWrData,
  output logic              cntDone,
  output logic              tmoDone,
  output logic              pdEn,
  output logic [PORT_W-1:0] cfgOut,
  output logic [1:0]        rstCause
);

  localparam int CNT_W = (SEQ_CLKS > 1) ? $clog2(SEQ_CLKS) : 1;
  localparam int TMO_W = (BUS_TMO > 1) ? $clog2(BUS_TMO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEQ_CLKS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(BUS_TMO - 1);

  logic [CNT_W-1:0]  seqCnt;
  logic [TMO_W-1:0]  tmoCnt;
  logic [PORT_W-1:0] cfgQ;
  logic [PORT_W-1:0] cfgNxt;
  rstSrc_e           causeQ;

  // sequence length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           seqCnt <= '0;
    else if (stb.cntClr) seqCnt <= '0;
    else if (stb.cntInc) seqCnt <= seqCnt + 1'b1;
  end
  assign cntDone = (seqCnt == CNT_LAST);

  // bus wait timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tmoCnt <= '0;
    else if (stb.tmoClr) tmoCnt <= '0;
    else if (stb.tmoInc) tmoCnt <= tmoCnt + 1'b1;
  end
  assign tmoDone = (tmoCnt == TMO_LAST);

  // pulldown enable bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pdEn <= 1'b0;
    else if (stb.pdClr) pdEn <= 1'b0;
    else if (stb.pdLd)  pdEn <= pdEnWrData;
  end

  // cause register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            causeQ <= SRC_EXT;
    else if (stb.causeLd) causeQ <= stb.causeVal;
  end
  assign rstCause = causeQ;

  // per-bit capture rule, chosen by the bit's field membership
  for (genvar b = 0; b < PORT_W; b++) begin : g_cfgBit
    if ((b >= HI_LSB) && (b <= HI_MSB)) begin : g_hi
      assign cfgNxt[b] = (stb.latchFull | stb.latchHi) ? portIn[b] : cfgQ[b];
    end else if ((b >= LO_LSB) && (b <= LO_MSB)) begin : g_lo
      assign cfgNxt[b] = stb.latchFull ? portIn[b] :
                         stb.latchHi   ? 1'b0      : cfgQ[b];
    end else begin : g_keep
      assign cfgNxt[b] = stb.latchFull ? portIn[b] : cfgQ[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNxt;
  end
  assign cfgOut = cfgQ;

  // checks
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    seqCnt <= CNT_LAST);

  assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    tmoCnt <= TMO_LAST);

  assert_lo_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchHi |=> (cfgQ[LO_MSB:LO_LSB] == '0));

  assert_pd_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.pdClr |=> !pdEn);

  assert_one_rule_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latchFull, stb.latchHi}));

endmodule

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstInLow,
  input  logic       supplyLow,
  input  logic       swRstReq,
  input  logic       wdtOvf,
  input  logic       busActive,
  input  logic       busUsesReady,
  input  logic       busWaitDone,
  input  logic       readyN,
  input  logic       einit,
  input  logic       pdEnWr,
  input  logic       cntDone,
  input  logic       tmoDone,
  input  logic       pdEn,
  output seqStrobe_t stb,
  output logic       intRst,
  output logic       rstOutLow,
  output logic       rstInPullLow,
  output logic       busAbort
);

  seqState_e state, nxtState;
  rstSrc_e   src, nxtSrc, winSrc;
  logic      asyncNow, anyReq, waitDone, waitAbort;

  assign asyncNow = supplyLow & rstInLow;
  assign anyReq   = rstInLow | wdtOvf | swRstReq;

  // fixed-priority arbitration
  always_comb begin
    if (asyncNow)      winSrc = SRC_ASYNC;
    else if (rstInLow) winSrc = SRC_EXT;
    else if (wdtOvf)   winSrc = SRC_WDT;
    else               winSrc = SRC_SW;
  end

  assign waitDone  = !busActive || (busUsesReady && busWaitDone && !readyN);
  assign waitAbort = !waitDone &&
                     ((busUsesReady && busWaitDone && readyN) || tmoDone);

  always_comb begin
    stb      = '0;
    nxtState = state;
    nxtSrc   = src;
    unique case (state)
      ST_RUN: begin
        if (anyReq) begin
          stb.causeLd  = 1'b1;
          stb.causeVal = winSrc;
          nxtSrc       = winSrc;
          if (winSrc == SRC_ASYNC) begin
            nxtState   = ST_ASYNC;
            stb.cntClr = 1'b1;
          end else if (winSrc == SRC_WDT && busActive) begin
            nxtState   = ST_BUSWAIT;
            stb.tmoClr = 1'b1;
          end else begin
            nxtState   = ST_SEQ;
            stb.cntClr = 1'b1;
          end
        end else begin
          stb.pdLd = pdEnWr;
        end
      end
      ST_BUSWAIT: begin
        if (rstInLow) begin
          stb.causeLd  = 1'b1;
          stb.causeVal = winSrc;
          nxtSrc       = winSrc;
          stb.cntClr   = 1'b1;
          nxtState     = asyncNow ? ST_ASYNC : ST_SEQ;
        end else if (waitDone || waitAbort) begin
          stb.cntClr = 1'b1;
          nxtState   = ST_SEQ;
        end else begin
          stb.tmoInc = 1'b1;
        end
      end
      ST_SEQ: begin
        if (anyReq) begin
          stb.causeLd  = 1'b1;
          stb.causeVal = winSrc;
          nxtSrc       = winSrc;
          stb.cntClr   = 1'b1;
          if (asyncNow) nxtState = ST_ASYNC;
        end else if (cntDone) begin
          nxtState = ST_RUN;
          stb.pdClr = 1'b1;
          if (src == SRC_EXT || src == SRC_ASYNC) stb.latchFull = 1'b1;
          else                                    stb.latchHi   = 1'b1;
        end else begin
          stb.cntInc = 1'b1;
        end
      end
      ST_ASYNC: begin
        stb.cntClr = 1'b1;
        stb.pdClr  = 1'b1;
        if (!asyncNow) nxtState = ST_SEQ;
      end
      default: nxtState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      src   <= SRC_EXT;
    end else begin
      state <= nxtState;
      src   <= nxtSrc;
    end
  end

  // reset-out: set by any sequence, cleared only by einit outside reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rstOutLow <= 1'b1;
    else if (nxtState == ST_SEQ || nxtState == ST_ASYNC)
      rstOutLow <= 1'b1;
    else if (einit && state == ST_RUN && !anyReq)
      rstOutLow <= 1'b0;
  end

  assign intRst       = (state == ST_SEQ) || (state == ST_ASYNC) || asyncNow;
  assign busAbort     = (state == ST_BUSWAIT) && !rstInLow && waitAbort;
  assign rstInPullLow = pdEn && (state == ST_SEQ) &&
                        (src == SRC_WDT || src == SRC_SW);

  // checks
  assert_async_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    asyncNow |=> (state == ST_ASYNC));

  assert_rstout_einit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutLow) |-> $past(einit));

  assert_abort_leaves_R5: assert property (@(posedge clk) disable iff (!rstN)
    busAbort |=> (state == ST_SEQ));

  assert_wait_no_rst_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSWAIT && !supplyLow) |-> !intRst);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int PORT_W      = 16,
  parameter int SEQ_UNITS   = 1024,
  parameter int TCL_PER_CLK = 2,
  parameter int BUS_TMO     = 16,
  parameter int HI_MSB      = 12,
  parameter int HI_LSB      = 8,
  parameter int LO_MSB      = 7,
  parameter int LO_LSB      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstInLow,
  input  logic              supplyLow,
  input  logic              swRstReq,
  input  logic              wdtOvf,
  input  logic              busActive,
  input  logic              busUsesReady,
  input  logic              busWaitDone,
  input  logic              readyN,
  input  logic              einit,
  input  logic              pdEnWr,
  input  logic              pdEnWrData,
  input  logic [PORT_W-1:0] portIn,
  output logic              intRst,
  output logic              rstOutLow,
  output logic              rstInPullLow,
  output logic              busAbort,
  output logic [PORT_W-1:0] cfgOut,
  output logic [1:0]        rstCause
);

  localparam int SEQ_CLKS = SEQ_UNITS / TCL_PER_CLK;

  seqStrobe_t stb;
  logic       cntDone, tmoDone, pdEn;

  reset_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rstInLow     (rstInLow),
    .supplyLow    (supplyLow),
    .swRstReq     (swRstReq),
    .wdtOvf       (wdtOvf),
    .busActive    (busActive),
    .busUsesReady (busUsesReady),
    .busWaitDone  (busWaitDone),
    .readyN       (readyN),
    .einit        (einit),
    .pdEnWr       (pdEnWr),
    .cntDone      (cntDone),
    .tmoDone      (tmoDone),
    .pdEn         (pdEn),
    .stb          (stb),
    .intRst       (intRst),
    .rstOutLow    (rstOutLow),
    .rstInPullLow (rstInPullLow),
    .busAbort     (busAbort)
  );

  reset_seq_dp #(
    .PORT_W   (PORT_W),
    .SEQ_CLKS (SEQ_CLKS),
    .BUS_TMO  (BUS_TMO),
    .HI_MSB   (HI_MSB),
    .HI_LSB   (HI_LSB),
    .LO_MSB   (LO_MSB),
    .LO_LSB   (LO_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .portIn     (portIn),
    .pdEnWrData (pdEnWrData),
    .cntDone    (cntDone),
    .tmoDone    (tmoDone),
    .pdEn       (pdEn),
    .cfgOut     (cfgOut),
    .rstCause   (rstCause)
  );

endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;

  localparam int PW  = 16;
  localparam int SU  = 16;
  localparam int TPC = 2;
  localparam int SC  = SU / TPC;
  localparam int BT  = 4;
  localparam logic [PW-1:0] HI_M = PW'(((1 << 5) - 1) << 8);
  localparam logic [PW-1:0] LO_M = PW'(((1 << 6) - 1) << 2);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, rstInLow, supplyLow, swRstReq, wdtOvf, busActive, busUsesReady;
  logic busWaitDone, readyN, einit, pdEnWr, pdEnWrData;
  logic [PW-1:0] portIn, cfgOut;
  logic intRst, rstOutLow, rstInPullLow, busAbort;
  logic [1:0] rstCause;

  reset_sequencer #(.PORT_W(PW), .SEQ_UNITS(SU), .TCL_PER_CLK(TPC), .BUS_TMO(BT)) u_dut (
    .clk(clk), .rstN(rstN), .rstInLow(rstInLow), .supplyLow(supplyLow),
    .swRstReq(swRstReq), .wdtOvf(wdtOvf), .busActive(busActive),
    .busUsesReady(busUsesReady), .busWaitDone(busWaitDone), .readyN(readyN),
    .einit(einit), .pdEnWr(pdEnWr), .pdEnWrData(pdEnWrData), .portIn(portIn),
    .intRst(intRst), .rstOutLow(rstOutLow), .rstInPullLow(rstInPullLow),
    .busAbort(busAbort), .cfgOut(cfgOut), .rstCause(rstCause)
  );

  int nVec = 0;
  int nBad = 0;
  logic [PW-1:0] expCfg;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ruleFull(input logic [PW-1:0] p);
    return p;
  endfunction

  function automatic logic [PW-1:0] ruleHi(input logic [PW-1:0] old, input logic [PW-1:0] p);
    return (old & ~(HI_M | LO_M)) | (p & HI_M);
  endfunction

  task automatic waitIdle(output int n);
    n = 0;
    while (intRst === 1'b1 && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  // kind: 0 software, 1 watchdog, 2 external, 3 low-supply
  task automatic runSrc(input int kind, input logic [PW-1:0] p);
    int n;
    @(negedge clk);
    portIn = p;
    case (kind)
      0: swRstReq = 1'b1;
      1: wdtOvf   = 1'b1;
      2: rstInLow = 1'b1;
      default: begin rstInLow = 1'b1; supplyLow = 1'b1; end
    endcase
    if (kind == 3) begin
      #1 chk("R9 intRst same cycle", intRst, 1);
      @(negedge clk);
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    swRstReq = 0; wdtOvf = 0; rstInLow = 0; supplyLow = 0;
    #1;
    waitIdle(n);
    chk("R1 sequence length", n, (kind == 3) ? SC + 1 : SC);
    if (kind >= 2) expCfg = ruleFull(p);
    else           expCfg = ruleHi(expCfg, p);
    chk((kind == 0) ? "R3 sw capture" : (kind == 1) ? "R4 wdt capture" :
        (kind == 2) ? "R2 ext capture" : "R9 async capture", cfgOut, expCfg);
    chk("R10 cause", rstCause, kind);
  endtask

  initial begin
    int n, k, ab;
    logic [PW-1:0] p;
    rstN = 0; rstInLow = 0; supplyLow = 0; swRstReq = 0; wdtOvf = 0;
    busActive = 0; busUsesReady = 0; busWaitDone = 0; readyN = 1;
    einit = 0; pdEnWr = 0; pdEnWrData = 0; portIn = '0;
    expCfg = '0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset intRst", intRst, 0);
    chk("R2 reset cfg", cfgOut, 0);
    chk("R10 reset cause", rstCause, 2);
    chk("R7 reset rstOut", rstOutLow, 1);
    chk("R8 reset pull", rstInPullLow, 0);
    chk("R5 reset abort", busAbort, 0);

    // sweep all sources over computed patterns
    for (int i = 0; i < 8; i++) begin
      for (int kk = 0; kk < 4; kk++) begin
        p = PW'(16'hA5C3 ^ (i * 16'h1111) ^ (kk * 16'h0F0F));
        runSrc(kk, p);
      end
    end

    // R7 einit during reset ignored, outside reset releases
    @(negedge clk); swRstReq = 1;
    @(negedge clk); swRstReq = 0; einit = 1;
    @(negedge clk); einit = 0;
    waitIdle(n);
    expCfg = ruleHi(expCfg, portIn);
    chk("R7 einit in reset ignored", rstOutLow, 1);
    einit = 1;
    @(negedge clk); einit = 0;
    chk("R7 einit releases", rstOutLow, 0);
    @(negedge clk); wdtOvf = 1;
    @(negedge clk); wdtOvf = 0;
    chk("R7 reasserted", rstOutLow, 1);
    waitIdle(n);
    expCfg = ruleHi(expCfg, portIn);

    // R8 pulldown
    pdEnWr = 1; pdEnWrData = 1;
    @(negedge clk); pdEnWr = 0; rstInLow = 1;
    @(negedge clk); rstInLow = 0;
    chk("R8 no pull on ext", rstInPullLow, 0);
    waitIdle(n); expCfg = ruleFull(portIn);
    pdEnWr = 1; pdEnWrData = 1;
    @(negedge clk); pdEnWr = 0; swRstReq = 1;
    @(negedge clk); swRstReq = 0;
    chk("R8 pull on sw", rstInPullLow, 1);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);
    chk("R8 pull off after", rstInPullLow, 0);
    @(negedge clk); swRstReq = 1;
    @(negedge clk); swRstReq = 0;
    chk("R8 bit cleared by end", rstInPullLow, 0);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);

    // R5 abort by ready high
    portIn = 16'h3C5A;
    busActive = 1; busUsesReady = 1; wdtOvf = 1;
    @(negedge clk); wdtOvf = 0;
    chk("R5 held off", intRst, 0);
    chk("R5 cause wdt", rstCause, 1);
    @(negedge clk);
    chk("R5 still held", intRst, 0);
    busWaitDone = 1; readyN = 1;
    #1 chk("R5 abort on ready high", busAbort, 1);
    @(negedge clk); busWaitDone = 0; busActive = 0;
    chk("R5 seq after abort", intRst, 1);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);
    chk("R5 length", n, SC);
    chk("R4 cfg after bus wait", cfgOut, expCfg);

    // R5 completion by ready low
    busActive = 1; busUsesReady = 1; wdtOvf = 1;
    @(negedge clk); wdtOvf = 0;
    busWaitDone = 1; readyN = 0;
    #1 chk("R5 no abort on ready low", busAbort, 0);
    @(negedge clk); busWaitDone = 0; busActive = 0; readyN = 1;
    chk("R5 seq after completion", intRst, 1);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);

    // R5 cycle without ready ends when bus drops
    busActive = 1; busUsesReady = 0; wdtOvf = 1;
    @(negedge clk); wdtOvf = 0;
    @(negedge clk);
    chk("R5 no-ready wait", intRst, 0);
    chk("R5 no-ready no abort", busAbort, 0);
    busActive = 0;
    @(negedge clk);
    chk("R5 start after bus end", intRst, 1);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);

    // R6 timeout
    busActive = 1; busUsesReady = 1; wdtOvf = 1;
    @(negedge clk); wdtOvf = 0;
    k = 0; ab = 0;
    while (intRst === 1'b0 && k < 50) begin
      if (busAbort === 1'b1) ab++;
      k++;
      @(negedge clk);
    end
    chk("R6 timeout cycles", k, BT);
    chk("R6 single abort", ab, 1);
    busActive = 0;
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);

    // R12 sw and ext do not wait for the bus
    busActive = 1; busUsesReady = 1; swRstReq = 1;
    @(negedge clk); swRstReq = 0;
    chk("R12 sw immediate", intRst, 1);
    chk("R12 sw no abort", busAbort, 0);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);
    rstInLow = 1;
    @(negedge clk); rstInLow = 0;
    chk("R12 ext immediate", intRst, 1);
    chk("R12 ext no abort", busAbort, 0);
    waitIdle(n); expCfg = ruleFull(portIn);
    busActive = 0;

    // R10 same-cycle priority
    swRstReq = 1; wdtOvf = 1;
    @(negedge clk); swRstReq = 0; wdtOvf = 0;
    chk("R10 wdt over sw", rstCause, 1);
    waitIdle(n); expCfg = ruleHi(expCfg, portIn);
    rstInLow = 1; wdtOvf = 1;
    @(negedge clk); rstInLow = 0; wdtOvf = 0;
    chk("R10 ext over wdt", rstCause, 2);
    waitIdle(n); expCfg = ruleFull(portIn);
    rstInLow = 1; supplyLow = 1; swRstReq = 1;
    @(negedge clk); rstInLow = 0; supplyLow = 0; swRstReq = 0;
    chk("R10 async over all", rstCause, 3);
    waitIdle(n); expCfg = ruleFull(portIn);

    // R11 restart, newest rule wins
    portIn = 16'hFFFF; expCfg = ruleFull(16'h0000);
    rstInLow = 1; portIn = 16'h0000;
    @(negedge clk); rstInLow = 0;
    waitIdle(n);
    portIn = 16'hFFFF;
    rstInLow = 1;
    @(negedge clk); rstInLow = 0;
    @(negedge clk); @(negedge clk);
    swRstReq = 1;
    @(negedge clk); swRstReq = 0;
    waitIdle(n);
    chk("R11 restarted length", n + 3, 3 + SC);
    expCfg = ruleHi(16'h0000, 16'hFFFF);
    chk("R11 newest rule", cfgOut, expCfg);
    chk("R11 newest cause", rstCause, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule